// File: doc/BRIEF.md
# SPI Host Byte-Counted Word Transfer Engine

This block is the transmit and receive engine of an SPI host. Software programs a byte count from 1 to 255 and enables counted mode. Writing the first 32-bit data word then starts a transaction. Each word is sent low byte first, and each byte is sent most significant bit first, in SPI mode 0. The bytes that come back on MISO are packed into 32-bit words in the same order.

The byte count does not have to be a multiple of four. The last word may therefore be partial: its receive word has zeros in the unused upper bytes, and the final receive-complete pulse comes on the last byte. A single 32-bit holding register sits between the data write port and the shifter. The data-register-empty flag tells software when the next word can be written. If software falls behind at a word boundary, SCK pauses low with SS still asserted until the word arrives.

A level transmit-complete flag marks the end of the transaction and the return of SS. A new transaction may start only while that flag is high.

Top module: `spi_len_host`

## Requirements
- R1: A data write starts a transaction only if the engine is idle, transmit-complete is 1, length-enable is 1 and the length is in 1..255. A write with length-enable 0 or length 0 is ignored: ss_n stays 1, SCK stays low and txc stays 1.
- R2: With divider value D, ss_n falls D+1 clocks before the first SCK rising edge. Without a stall, consecutive SCK edges are D+1 clocks apart. ss_n rises D+1 clocks after the last SCK falling edge.
- R3: A transaction produces exactly 8×length SCK rising edges. SCK idles low and is low whenever ss_n is 1. MOSI changes only while SCK is low. MISO is sampled on the SCK rising edge (mode 0).
- R4: Transaction byte j is bits [8(j mod 4)+7 : 8(j mod 4)] of written word j/4, and it is shifted out MSB first.
- R5: rx_cmp pulses for one clock after every fourth received byte. rx_word holds the first received byte of that word in bits [7:0], the second in [15:8], the third in [23:16] and the fourth in [31:24].
- R6: If the length is not a multiple of 4, rx_cmp also pulses after the last byte, and the unused upper bytes of that rx_word are 0. A transaction gives exactly ceil(length/4) rx_cmp pulses.
- R7: dre is 1 after reset and whenever the holding register is empty. An accepted mid-transaction write drives it to 0. It returns to 1 when the word moves to the shifter. The first word goes straight to the shifter, so dre stays 1 after the starting write.
- R8: During a transaction a data write is accepted only if dre is 1 and fewer than ceil(length/4) words have been written. Any other write is ignored and leaves the transmitted bytes unchanged.
- R9: txc is 1 after reset. The starting write clears it, and it is set on the same clock edge on which ss_n returns to 1.
- R10: If the holding register is empty at a word boundary, SCK stays low and ss_n stays 0 until a word is written. SCK then resumes D+1 clocks after that word is taken, and no data is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted in step with clk |
| cfg_len | input | 8 | Transaction length in bytes (1..255) |
| cfg_len_en | input | 1 | Enables byte-counted transactions |
| clk_div | input | 8 | SCK divider D; SCK = clk / (2·(D+1)) |
| wr_valid | input | 1 | One-clock data register write strobe |
| wr_data | input | 32 | Data word to transmit |
| dre | output | 1 | Holding register empty, next word may be written |
| txc | output | 1 | Transaction complete, engine idle |
| rx_cmp | output | 1 | One-clock pulse: rx_word holds a newly completed word |
| rx_word | output | 32 | Last completed receive word |
| sck | output | 1 | SPI serial clock |
| mosi | output | 1 | SPI host data out |
| miso | input | 1 | SPI host data in |
| ss_n | output | 1 | Active-low select, held low for the whole transaction |

## Verification
The checker watches every clock for these properties:
- SCK is low whenever SS is released, and MOSI never moves while SCK is high.
- Transmit-complete is only ever seen with SS released, and it rises together with SS.
- Receive-complete pulses occur only inside a frame, and the holding register is empty whenever the engine is idle.

Some behaviour is visible only in the bench's sweeps over lengths, dividers and write timing:
- the byte and bit order on MOSI and in the packed receive words;
- the exact edge counts and the spacing of SS and SCK edges;
- the zero fill of a partial last word;
- the rejection of surplus or overlapping writes;
- the resumption after a stall.

// File: rtl/spi_len_pkg.sv
package spi_len_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_STALL = 2'd2,
    ST_TAIL  = 2'd3
  } eng_state_t;
endpackage

// File: rtl/spi_len_clkdiv.sv
// Half-period tick generator: one tick every (div+1) clocks while run is high.
module spi_len_clkdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == div);

  always_comb begin
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/spi_len_holdbuf.sv
// Single-word transmit holding register between the write port and the shifter.
module spi_len_holdbuf #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [WORD_W-1:0] push_data,
  input  logic              pop,
  output logic              full,
  output logic [WORD_W-1:0] data
);
  logic              full_q, full_d;
  logic [WORD_W-1:0] data_q, data_d;

  always_comb begin
    full_d = full_q;
    data_d = data_q;
    if (pop)  full_d = 1'b0;
    if (push) begin
      full_d = 1'b1;
      data_d = push_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      full_q <= full_d;
      if (push) data_q <= data_d;
    end
  end

  assign full = full_q;
  assign data = data_q;
endmodule

// File: rtl/spi_len_host.sv
// SPI host engine: byte-counted transactions built from 32-bit words, mode 0.
// rst_n is asserted asynchronously and must be released in step with clk.
module spi_len_host #(
  parameter int LEN_W  = 8,
  parameter int DIV_W  = 8,
  parameter int WORD_W = 32   // power-of-two multiple of 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic              cfg_len_en,
  input  logic [DIV_W-1:0]  clk_div,
  input  logic              wr_valid,
  input  logic [WORD_W-1:0] wr_data,
  output logic              dre,
  output logic              txc,
  output logic              rx_cmp,
  output logic [WORD_W-1:0] rx_word,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic              ss_n
);
  import spi_len_pkg::*;

  localparam int NB     = WORD_W / 8;
  localparam int BIDX_W = (NB > 1) ? $clog2(NB) : 1;
  localparam int CNT_W  = LEN_W + 1;

  eng_state_t        state_q, state_d;
  logic              sck_q, sck_d, ss_n_q, ss_n_d, txc_q, txc_d, rx_cmp_q, rx_cmp_d;
  logic [WORD_W-1:0] tx_word_q, tx_word_d, rx_acc_q, rx_acc_d, rx_word_q, rx_word_d;
  logic [BIDX_W-1:0] bidx_q, bidx_d;
  logic [2:0]        bitc_q, bitc_d;
  logic [LEN_W-1:0]  nbytes_q, nbytes_d, len_q, len_d;
  logic [CNT_W-1:0]  nwords_q, nwords_d, words_total;
  logic [DIV_W-1:0]  div_q, div_d;

  logic              tick, run, start, push, pop, hold_full;
  logic              byte_end, last_sel, word_bnd;
  logic [WORD_W-1:0] hold_data;

  assign words_total = CNT_W'(({1'b0, len_q} + CNT_W'(NB - 1)) >> BIDX_W);
  assign start = (state_q == ST_IDLE) && wr_valid && txc_q && cfg_len_en && (cfg_len != '0);
  assign push  = (state_q != ST_IDLE) && wr_valid && !hold_full && (nwords_q < words_total);
  assign run   = (state_q == ST_SHIFT) || (state_q == ST_TAIL);

  assign byte_end = (state_q == ST_SHIFT) && tick && sck_q && (bitc_q == 3'd7);
  assign last_sel = (nbytes_q == len_q - 1'b1);
  assign word_bnd = byte_end && !last_sel && (bidx_q == BIDX_W'(NB - 1));
  assign pop      = (word_bnd && hold_full) || ((state_q == ST_STALL) && hold_full);

  spi_len_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(run), .div(div_q), .tick(tick)
  );

  spi_len_holdbuf #(.WORD_W(WORD_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data(wr_data),
    .pop(pop), .full(hold_full), .data(hold_data)
  );

  // next-state logic
  always_comb begin
    state_d   = state_q;
    sck_d     = sck_q;
    ss_n_d    = ss_n_q;
    txc_d     = txc_q;
    rx_cmp_d  = 1'b0;
    tx_word_d = tx_word_q;
    rx_acc_d  = rx_acc_q;
    rx_word_d = rx_word_q;
    bidx_d    = bidx_q;
    bitc_d    = bitc_q;
    nbytes_d  = nbytes_q;
    nwords_d  = nwords_q;
    len_d     = len_q;
    div_d     = div_q;

    if (start) begin
      state_d   = ST_SHIFT;
      ss_n_d    = 1'b0;
      txc_d     = 1'b0;
      tx_word_d = wr_data;
      rx_acc_d  = '0;
      bidx_d    = '0;
      bitc_d    = '0;
      nbytes_d  = '0;
      nwords_d  = CNT_W'(1);
      len_d     = cfg_len;
      div_d     = clk_div;
    end
    if (push) nwords_d = nwords_q + 1'b1;

    case (state_q)
      ST_SHIFT: begin
        if (tick) begin
          if (!sck_q) begin
            sck_d = 1'b1;
            rx_acc_d[{bidx_q, ~bitc_q}] = miso;
          end else begin
            sck_d = 1'b0;
            if (bitc_q != 3'd7) begin
              bitc_d = bitc_q + 1'b1;
            end else begin
              bitc_d   = '0;
              nbytes_d = nbytes_q + 1'b1;
              if (last_sel) begin
                rx_cmp_d  = 1'b1;
                rx_word_d = rx_acc_q;
                state_d   = ST_TAIL;
              end else if (bidx_q == BIDX_W'(NB - 1)) begin
                rx_cmp_d  = 1'b1;
                rx_word_d = rx_acc_q;
                rx_acc_d  = '0;
                bidx_d    = '0;
                if (hold_full) tx_word_d = hold_data;
                else           state_d   = ST_STALL;
              end else begin
                bidx_d = bidx_q + 1'b1;
              end
            end
          end
        end
      end
      ST_STALL: begin
        if (hold_full) begin
          state_d   = ST_SHIFT;
          tx_word_d = hold_data;
        end
      end
      ST_TAIL: begin
        if (tick) begin
          state_d = ST_IDLE;
          ss_n_d  = 1'b1;
          txc_d   = 1'b1;
        end
      end
      default: ;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      sck_q     <= 1'b0;
      ss_n_q    <= 1'b1;
      txc_q     <= 1'b1;
      rx_cmp_q  <= 1'b0;
      tx_word_q <= '0;
      rx_acc_q  <= '0;
      rx_word_q <= '0;
      bidx_q    <= '0;
      bitc_q    <= '0;
      nbytes_q  <= '0;
      nwords_q  <= '0;
      len_q     <= '0;
      div_q     <= '0;
    end else begin
      state_q   <= state_d;
      sck_q     <= sck_d;
      ss_n_q    <= ss_n_d;
      txc_q     <= txc_d;
      rx_cmp_q  <= rx_cmp_d;
      tx_word_q <= tx_word_d;
      rx_acc_q  <= rx_acc_d;
      rx_word_q <= rx_word_d;
      bidx_q    <= bidx_d;
      bitc_q    <= bitc_d;
      nbytes_q  <= nbytes_d;
      nwords_q  <= nwords_d;
      len_q     <= len_d;
      div_q     <= div_d;
    end
  end

  assign mosi    = tx_word_q[{bidx_q, ~bitc_q}];
  assign sck     = sck_q;
  assign ss_n    = ss_n_q;
  assign txc     = txc_q;
  assign dre     = !hold_full;
  assign rx_cmp  = rx_cmp_q;
  assign rx_word = rx_word_q;
endmodule

// File: rtl/spi_len_host_chk.sv
module spi_len_host_chk (
  input logic clk,
  input logic rst_n,
  input logic sck,
  input logic ss_n,
  input logic mosi,
  input logic dre,
  input logic txc,
  input logic rx_cmp
);
  AST_SCK_LOW_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    ss_n |-> !sck); // R3
  AST_MOSI_STILL_SCK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> $stable(mosi)); // R3
  AST_TXC_ONLY_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    txc |-> ss_n); // R9
  AST_TXC_RISES_WITH_SS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(txc) |-> $rose(ss_n)); // R9
  AST_RXC_INSIDE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cmp |-> !ss_n); // R5
  AST_HOLD_EMPTY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ss_n |-> dre); // R7
endmodule

bind spi_len_host spi_len_host_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sck(sck), .ss_n(ss_n), .mosi(mosi),
  .dre(dre), .txc(txc), .rx_cmp(rx_cmp)
);

// File: tb/spi_len_host_bench.sv
module spi_len_host_bench;
  logic        clk, rst_n;
  logic [7:0]  cfg_len, clk_div;
  logic        cfg_len_en, wr_valid;
  logic [31:0] wr_data;
  logic        dre, txc, rx_cmp, sck, mosi, miso, ss_n;
  logic [31:0] rx_word;

  int checks = 0, fails = 0, seed = 0;

  spi_len_host u_spi_len_host (
    .clk(clk), .rst_n(rst_n), .cfg_len(cfg_len), .cfg_len_en(cfg_len_en),
    .clk_div(clk_div), .wr_valid(wr_valid), .wr_data(wr_data), .dre(dre),
    .txc(txc), .rx_cmp(rx_cmp), .rx_word(rx_word), .sck(sck), .mosi(mosi),
    .miso(miso), .ss_n(ss_n)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  // monitor / slave model state
  int  cyc = 0, nrise = 0, nrx = 0, sbit = 0, ss_falls = 0, ss_rises = 0;
  int  t_ssfall = 0, t_first = 0, t_lastfall = 0, t_ssrise = 0, t_edge = 0;
  int  min_iv = 0, max_iv = 0;
  logic prev_sck = 1'b0, prev_ss = 1'b1;
  logic        cap [0:2047];
  logic [31:0] rxw [0:63];

  function automatic logic [7:0] sbyte(input int k);
    return 8'(k * 29 + seed * 7 + 3);
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (prev_ss && !ss_n) begin
      ss_falls++; t_ssfall = cyc; nrise = 0; nrx = 0; sbit = 0;
      min_iv = 1 << 30; max_iv = 0;
    end else if (prev_sck && !sck && !ss_n) begin
      sbit++;
    end
    if (!prev_sck && sck) begin
      if (nrise == 0) t_first = cyc;
      else begin
        if (cyc - t_edge < min_iv) min_iv = cyc - t_edge;
        if (cyc - t_edge > max_iv) max_iv = cyc - t_edge;
      end
      if (nrise < 2048) cap[nrise] = mosi;
      nrise++; t_edge = cyc;
    end
    if (prev_sck && !sck) begin
      if (cyc - t_edge < min_iv) min_iv = cyc - t_edge;
      if (cyc - t_edge > max_iv) max_iv = cyc - t_edge;
      t_edge = cyc; t_lastfall = cyc;
    end
    if (!prev_ss && ss_n) begin ss_rises++; t_ssrise = cyc; end
    if (rx_cmp && nrx < 64) begin rxw[nrx] = rx_word; nrx++; end
    miso = sbyte(sbit / 8)[7 - (sbit % 8)];
    prev_sck = sck; prev_ss = ss_n;
  end

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic pulse_write(input logic [31:0] d);
    wr_valid = 1'b1; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic idle_write(input bit en, input int len);
    int f0;
    f0 = ss_falls;
    cfg_len_en = en; cfg_len = 8'(len);
    @(negedge clk);
    pulse_write(32'hA5A5_5A5A);
    repeat (30) @(negedge clk);
    chk(ss_n == 1'b1 && ss_falls == f0, "R1 write ignored, ss_n stays high", {31'd0, ss_n}, 32'd1);
    chk(txc == 1'b1 && sck == 1'b0, "R1 write ignored, txc stays set", {30'd0, txc, sck}, 32'd2);
  endtask

  task automatic run_txn(input int len, input int dv, input int gap, input bit junk);
    int nw, r0, guard, bad, badi;
    logic [31:0] wd [0:63];
    logic [31:0] ew;
    logic [7:0]  b;
    nw = (len + 3) / 4;
    seed++;
    for (int i = 0; i < nw; i++) wd[i] = (32'h9E37_79B9 * 32'(i + 1 + seed)) ^ 32'(seed);
    r0 = ss_rises;
    cfg_len = 8'(len); cfg_len_en = 1'b1; clk_div = 8'(dv);
    @(negedge clk);
    pulse_write(wd[0]);
    chk(txc == 1'b0 && ss_n == 1'b0, "R9 start clears txc and selects", {30'd0, txc, ss_n}, 32'd0);
    chk(dre == 1'b1, "R7 first word goes to shifter, dre stays 1", {31'd0, dre}, 32'd1);
    for (int i = 1; i < nw; i++) begin
      guard = 0;
      while (!dre && guard < 20000) begin @(negedge clk); guard++; end
      if (gap > 0) repeat (gap) @(negedge clk);
      pulse_write(wd[i]);
      chk(dre == 1'b0, "R7 accepted write clears dre", {31'd0, dre}, 32'd0);
    end
    if (junk) begin
      pulse_write(32'hDEAD_BEEF);
      if (nw == 1) chk(dre == 1'b1, "R8 surplus write ignored, dre stays 1", {31'd0, dre}, 32'd1);
    end
    guard = 0;
    while (!txc && guard < 40000) begin @(negedge clk); guard++; end
    repeat (2) @(negedge clk);
    chk(txc == 1'b1 && ss_rises == r0 + 1, "R9/R10 one release, txc set", 32'(ss_rises - r0), 32'd1);
    chk(t_ssrise == t_lastfall + dv + 1, "R2 ss_n rises D+1 after last fall", 32'(t_ssrise - t_lastfall), 32'(dv + 1));
    chk(t_first == t_ssfall + dv + 1, "R2 ss_n falls D+1 before first rise", 32'(t_first - t_ssfall), 32'(dv + 1));
    if (len > 1 || dv >= 0) chk(min_iv == dv + 1, "R2 half period", 32'(min_iv), 32'(dv + 1));
    if (gap == 0) chk(max_iv == dv + 1, "R2 no stretched half period", 32'(max_iv), 32'(dv + 1));
    else if (nw > 1) chk(max_iv > dv + 1, "R10 SCK paused while buffer empty", 32'(max_iv), 32'(dv + 2));
    chk(nrise == 8 * len, "R3 rising edge count", 32'(nrise), 32'(8 * len));
    bad = 0; badi = 0;
    for (int n = 0; n < 8 * len; n++) begin
      b = wd[(n / 8) / 4][8 * ((n / 8) % 4) +: 8];
      if (bad == 0 && cap[n] !== b[7 - (n % 8)]) begin bad = 1; badi = n; end
    end
    chk(bad == 0, (junk ? "R4/R8 MOSI stream (junk ignored)" : "R4 MOSI byte and bit order"), 32'(badi), 32'd0);
    chk(nrx == nw, "R6 rx_cmp pulse count", 32'(nrx), 32'(nw));
    for (int w = 0; w < nw && w < nrx; w++) begin
      for (int k = 0; k < 4; k++) ew[8 * k +: 8] = (4 * w + k < len) ? sbyte(4 * w + k) : 8'h00;
      chk(rxw[w] == ew, ((4 * w + 4 > len) ? "R6 partial word zero fill" : "R5 packed receive word"), rxw[w], ew);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired (R1..R10 not all reached)");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_valid = 1'b0; wr_data = '0; cfg_len = 8'd0; cfg_len_en = 1'b0; clk_div = 8'd0; miso = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ss_n == 1'b1 && sck == 1'b0, "R3 reset: deselected, SCK low", {30'd0, ss_n, sck}, 32'd2);
    chk(dre == 1'b1, "R7 reset: dre set", {31'd0, dre}, 32'd1);
    chk(txc == 1'b1 && rx_cmp == 1'b0, "R9 reset: txc set, no rx_cmp", {30'd0, txc, rx_cmp}, 32'd2);

    idle_write(1'b0, 8);    // R1 length disabled
    idle_write(1'b1, 0);    // R1 zero length

    for (int dv = 0; dv < 3; dv++)
      for (int len = 1; len <= 13; len++)
        run_txn(len, dv, 0, 1'b0);

    run_txn(5, 0, 100, 1'b0);     // R10 stall after word 0
    run_txn(9, 1, 160, 1'b0);     // R10
    run_txn(13, 2, 220, 1'b0);    // R10
    run_txn(4, 1, 0, 1'b1);       // R8 surplus write, single word
    run_txn(8, 0, 0, 1'b1);       // R8 write while buffer full
    run_txn(255, 0, 0, 1'b0);     // boundary length

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule